// File: doc/BRIEF.md
# Coherent Cache Node Controller

This block is the controller that one caching node keeps for a single cache line under a directory-based coherence scheme. It tracks whether the line is absent, readable, or owned for writing, and it keeps the line's data word. The attached processor asks for read access, asks for write access, or writes a new value. The controller turns the access requests into messages to the home agent, applies the grants that come back, and gives up the line when the home agent tells it to.

There are three single-entry message paths to and from the home agent. An outbound request slot carries a read or write request. An inbound path carries grants and invalidations, and the controller consumes each message with a one-cycle take strobe. An outbound acknowledgement slot answers invalidations, and it carries the line data only when the line was owned for writing. A processor command that cannot be taken yet is not dropped. The controller holds it off by keeping `cpu_ready` low.

Top module: `cc_node_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `line_state` is Invalid (2'b00), `line_data` is zero, and `req_valid`, `ack_valid` and `line_data_valid` are low.
- R2: `line_state` takes only the codes Invalid 2'b00, Shared 2'b01 and Exclusive 2'b10, and never 2'b11.
- R3: A shared request (`cpu_op` 2'b01) is ready only when the line is Invalid, the request slot is empty and no inbound message is being taken. When it is accepted, the next cycle shows `req_valid`=1 and `req_excl`=0.
- R4: An exclusive request (`cpu_op` 2'b10) is ready when the line is not Exclusive, the request slot is empty and no inbound message is being taken. When it is accepted, the next cycle shows `req_valid`=1 and `req_excl`=1.
- R5: A request held in the slot stays, with the same payload, until a cycle with `req_take` high. The slot is empty on the cycle after that.
- R6: An inbound grant is taken in the cycle it is presented, so `dn_take` is high in that cycle. `dn_kind` 2'b01 makes the line Shared and 2'b10 makes it Exclusive. In both cases `line_data` becomes `dn_data`.
- R7: An invalidation (`dn_kind` 2'b11) presented while the acknowledgement slot is empty is taken in that cycle. The line becomes Invalid, and the next cycle shows `ack_valid`=1. `ack_has_data` is 1 and `ack_data` is the old line data only if the line was Exclusive; otherwise both are 0.
- R8: An invalidation presented while the acknowledgement slot is full is not taken (`dn_take`=0), and the line state and data do not change.
- R9: An acknowledgement stays in its slot until a cycle with `ack_take` high.
- R10: A store (`cpu_op` 2'b11) is ready only when the line is Exclusive and no inbound message is being taken. When it is accepted, `line_data` becomes `cpu_wdata` on the next cycle.
- R11: A command that is not ready leaves `cpu_ready` low and changes nothing. `cpu_op` 2'b00 is never ready.
- R12: `line_data_valid` is high exactly when the line is not Invalid, and `line_data` is zero whenever the line is Invalid.

Port widths below use the default `DATA_W` = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor command present |
| cpu_op | input | 2 | Command: 01 read request, 10 write request, 11 store |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Command accepted this cycle if valid |
| req_valid | output | 1 | Request slot full |
| req_excl | output | 1 | Request kind: 1 exclusive, 0 shared |
| req_take | input | 1 | Home agent consumes the request |
| dn_valid | input | 1 | Inbound message present |
| dn_kind | input | 2 | 01 shared grant, 10 exclusive grant, 11 invalidate |
| dn_data | input | DATA_W | Grant data |
| dn_take | output | 1 | Inbound message consumed this cycle |
| ack_valid | output | 1 | Acknowledgement slot full |
| ack_has_data | output | 1 | Acknowledgement carries line data |
| ack_data | output | DATA_W | Written-back data |
| ack_take | input | 1 | Home agent consumes the acknowledgement |
| line_state | output | 2 | 00 Invalid, 01 Shared, 10 Exclusive |
| line_data | output | DATA_W | Cached data word |
| line_data_valid | output | 1 | Line holds a valid copy |

## Verification
The assertions check the following on every cycle:
- the line-state code is legal;
- both message slots hold steady until they are taken and are never overwritten;
- an invalidation empties the line and zeroes its data;
- a store lands only on an Exclusive line;
- a blocked invalidation is not consumed;
- a refused command leaves the request slot untouched.

Other behaviour only the bench scenarios can show. That covers the exact enabling conditions for each processor command and the grant data that gets installed. It also covers the data payload an acknowledgement carries from each starting state. The bench drives a long pseudo-random mix of commands, grants, invalidations and slot drains against a reference model written from the requirements.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10
  } line_st_t;

  localparam logic [1:0] OP_NONE  = 2'b00;
  localparam logic [1:0] OP_GETS  = 2'b01;
  localparam logic [1:0] OP_GETX  = 2'b10;
  localparam logic [1:0] OP_STORE = 2'b11;

  localparam logic [1:0] MSG_GNT_S = 2'b01;
  localparam logic [1:0] MSG_GNT_X = 2'b10;
  localparam logic [1:0] MSG_INV   = 2'b11;

endpackage

// File: rtl/cc_slot.sv
module cc_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         take,
  input  logic [W-1:0] din,
  output logic         valid,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && !take) |=> (valid && $stable(dout))); // R5

  AST_SLOT_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    load |-> !valid); // R9

endmodule

// File: rtl/cc_line.sv
module cc_line
  import cc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gnt_s,
  input  logic              gnt_x,
  input  logic              inv,
  input  logic              store,
  input  logic [DATA_W-1:0] gnt_data,
  input  logic [DATA_W-1:0] st_data,
  output line_st_t          state,
  output logic [DATA_W-1:0] data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= LS_INV;
      data  <= '0;
    end else if (inv) begin
      state <= LS_INV;
      data  <= '0;
    end else if (gnt_s) begin
      state <= LS_SHR;
      data  <= gnt_data;
    end else if (gnt_x) begin
      state <= LS_EXC;
      data  <= gnt_data;
    end else if (store) begin
      data  <= st_data;
    end
  end

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    state != 2'b11); // R2

  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (rst)
    inv |=> (state == LS_INV && data == '0)); // R7

  AST_STORE_ONLY_EXCL: assert property (@(posedge clk) disable iff (rst)
    store |-> state == LS_EXC); // R10

  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state == LS_INV) |-> (data == '0)); // R12

endmodule

// File: rtl/cc_node_ctrl.sv
module cc_node_ctrl
  import cc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              req_valid,
  output logic              req_excl,
  input  logic              req_take,
  input  logic              dn_valid,
  input  logic [1:0]        dn_kind,
  input  logic [DATA_W-1:0] dn_data,
  output logic              dn_take,
  output logic              ack_valid,
  output logic              ack_has_data,
  output logic [DATA_W-1:0] ack_data,
  input  logic              ack_take,
  output logic [1:0]        line_state,
  output logic [DATA_W-1:0] line_data,
  output logic              line_data_valid
);

  localparam int ACK_W = DATA_W + 1;

  line_st_t          st;
  logic              is_gs, is_gx, is_inv, inv_ok;
  logic              op_en, accept, req_load, st_apply;
  logic [ACK_W-1:0]  ack_din, ack_dout;
  logic              was_excl;

  // inbound message decode: grants always taken, invalidation needs a free ack slot
  always_comb begin
    is_gs   = dn_valid && (dn_kind == MSG_GNT_S);
    is_gx   = dn_valid && (dn_kind == MSG_GNT_X);
    is_inv  = dn_valid && (dn_kind == MSG_INV);
    inv_ok  = is_inv && !ack_valid;
    dn_take = is_gs || is_gx || inv_ok;
  end

  // processor command enable; inbound traffic has priority
  always_comb begin
    unique case (cpu_op)
      OP_GETS:  op_en = (st == LS_INV) && !req_valid;
      OP_GETX:  op_en = (st != LS_EXC) && !req_valid;
      OP_STORE: op_en = (st == LS_EXC);
      default:  op_en = 1'b0;
    endcase
    cpu_ready = op_en && !dn_take;
    accept    = cpu_valid && cpu_ready;
    req_load  = accept && (cpu_op == OP_GETS || cpu_op == OP_GETX);
    st_apply  = accept && (cpu_op == OP_STORE);
  end

  always_comb begin
    was_excl = (st == LS_EXC);
    ack_din  = {was_excl, (was_excl ? line_data : {DATA_W{1'b0}})};
  end

  cc_slot #(.W(1)) u_req_slot (
    .clk   (clk),
    .rst   (rst),
    .load  (req_load),
    .take  (req_take),
    .din   (cpu_op == OP_GETX),
    .valid (req_valid),
    .dout  (req_excl)
  );

  cc_slot #(.W(ACK_W)) u_ack_slot (
    .clk   (clk),
    .rst   (rst),
    .load  (inv_ok),
    .take  (ack_take),
    .din   (ack_din),
    .valid (ack_valid),
    .dout  (ack_dout)
  );

  assign ack_has_data = ack_dout[ACK_W-1];
  assign ack_data     = ack_dout[DATA_W-1:0];

  cc_line #(.DATA_W(DATA_W)) u_line (
    .clk      (clk),
    .rst      (rst),
    .gnt_s    (is_gs),
    .gnt_x    (is_gx),
    .inv      (inv_ok),
    .store    (st_apply),
    .gnt_data (dn_data),
    .st_data  (cpu_wdata),
    .state    (st),
    .data     (line_data)
  );

  assign line_state      = st;
  assign line_data_valid = (st != LS_INV);

  AST_INV_WAITS: assert property (@(posedge clk) disable iff (rst)
    (is_inv && ack_valid) |-> !dn_take); // R8

  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && !cpu_ready && !req_valid) |=> !req_valid); // R11

  AST_REQ_KIND: assert property (@(posedge clk) disable iff (rst)
    (req_load && cpu_op == OP_GETS) |=> (req_valid && !req_excl)); // R3

  AST_SHARED_ONLY_FROM_INV: assert property (@(posedge clk) disable iff (rst)
    (req_load && cpu_op == OP_GETS) |-> line_state == 2'b00); // R3

  AST_XREQ_NOT_OWNED: assert property (@(posedge clk) disable iff (rst)
    req_load |-> line_state != 2'b10); // R4

endmodule

// File: tb/cc_node_ctrl_bench.sv
`timescale 1ns/1ps
module cc_node_ctrl_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_valid = 1'b0;
  logic [1:0]    cpu_op = 2'b00;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic          req_valid, req_excl;
  logic          req_take = 1'b0;
  logic          dn_valid = 1'b0;
  logic [1:0]    dn_kind = 2'b00;
  logic [DW-1:0] dn_data = '0;
  logic          dn_take;
  logic          ack_valid, ack_has_data;
  logic [DW-1:0] ack_data;
  logic          ack_take = 1'b0;
  logic [1:0]    line_state;
  logic [DW-1:0] line_data;
  logic          line_data_valid;

  always #10 clk = ~clk;

  cc_node_ctrl #(.DATA_W(DW)) u_cc_node_ctrl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .req_valid(req_valid), .req_excl(req_excl), .req_take(req_take),
    .dn_valid(dn_valid), .dn_kind(dn_kind), .dn_data(dn_data), .dn_take(dn_take),
    .ack_valid(ack_valid), .ack_has_data(ack_has_data), .ack_data(ack_data), .ack_take(ack_take),
    .line_state(line_state), .line_data(line_data), .line_data_valid(line_data_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model state (codes: 0 Invalid, 1 Shared, 2 Exclusive)
  logic [1:0]    m_st;
  logic [DW-1:0] m_data;
  logic          m_rv, m_rx, m_av, m_ahd;
  logic [DW-1:0] m_ad;
  logic [31:0]   x;

  task automatic xs();
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
  endtask

  task automatic check_regs();
    chk("R2,R6", "line_state", {30'd0, line_state}, {30'd0, m_st});
    chk("R6,R10", "line_data", {24'd0, line_data}, {24'd0, m_data});
    chk("R12", "line_data_valid", {31'd0, line_data_valid}, {31'd0, m_st != 2'd0});
    chk("R5", "req_valid", {31'd0, req_valid}, {31'd0, m_rv});
    if (m_rv) chk("R3,R4", "req_excl", {31'd0, req_excl}, {31'd0, m_rx});
    chk("R9", "ack_valid", {31'd0, ack_valid}, {31'd0, m_av});
    if (m_av) begin
      chk("R7", "ack_has_data", {31'd0, ack_has_data}, {31'd0, m_ahd});
      chk("R7", "ack_data", {24'd0, ack_data}, {24'd0, m_ad});
    end
  endtask

  initial begin
    logic e_take, e_ready, e_inv_ok, e_gs, e_gx, e_acc;
    x = 32'h1234_5678;
    m_st = 2'd0; m_data = '0; m_rv = 0; m_rx = 0; m_av = 0; m_ahd = 0; m_ad = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset line_state", {30'd0, line_state}, 32'd0);
    chk("R1", "reset line_data", {24'd0, line_data}, 32'd0);
    chk("R1", "reset req_valid", {31'd0, req_valid}, 32'd0);
    chk("R1", "reset ack_valid", {31'd0, ack_valid}, 32'd0);
    chk("R1", "reset line_data_valid", {31'd0, line_data_valid}, 32'd0);
    rst = 1'b0;
    @(posedge clk); #1;
    check_regs();

    for (int i = 0; i < 5000; i++) begin
      xs();
      cpu_valid = (x[1:0] != 2'b00);
      cpu_op    = x[3:2];
      cpu_wdata = x[11:4];
      dn_valid  = (x[13:12] == 2'b00);
      dn_kind   = (x[15:14] == 2'b00) ? 2'b11 : x[15:14];
      dn_data   = x[23:16];
      req_take  = (x[25:24] == 2'b00);
      ack_take  = (x[28:26] == 3'b000);
      #4;
      e_gs     = dn_valid && dn_kind == 2'b01;
      e_gx     = dn_valid && dn_kind == 2'b10;
      e_inv_ok = dn_valid && dn_kind == 2'b11 && !m_av;
      e_take   = e_gs || e_gx || e_inv_ok;
      case (cpu_op)
        2'b01: e_ready = (m_st == 2'd0) && !m_rv && !e_take;
        2'b10: e_ready = (m_st != 2'd2) && !m_rv && !e_take;
        2'b11: e_ready = (m_st == 2'd2) && !e_take;
        default: e_ready = 1'b0;
      endcase
      chk((dn_valid && dn_kind == 2'b11) ? "R7,R8" : "R6", "dn_take",
          {31'd0, dn_take}, {31'd0, e_take});
      case (cpu_op)
        2'b01: chk("R3", "cpu_ready", {31'd0, cpu_ready}, {31'd0, e_ready});
        2'b10: chk("R4", "cpu_ready", {31'd0, cpu_ready}, {31'd0, e_ready});
        2'b11: chk("R10", "cpu_ready", {31'd0, cpu_ready}, {31'd0, e_ready});
        default: chk("R11", "cpu_ready", {31'd0, cpu_ready}, {31'd0, e_ready});
      endcase
      e_acc = cpu_valid && e_ready;

      @(posedge clk); #1;
      // model update
      if (e_inv_ok) begin
        m_av = 1'b1;
        m_ahd = (m_st == 2'd2);
        m_ad = (m_st == 2'd2) ? m_data : '0;
        m_st = 2'd0;
        m_data = '0;
      end else begin
        if (ack_take) m_av = 1'b0;
        if (e_gs) begin m_st = 2'd1; m_data = dn_data; end
        else if (e_gx) begin m_st = 2'd2; m_data = dn_data; end
      end
      if (e_acc && (cpu_op == 2'b01 || cpu_op == 2'b10)) begin
        m_rv = 1'b1;
        m_rx = (cpu_op == 2'b10);
      end else if (req_take) begin
        m_rv = 1'b0;
      end
      if (e_acc && cpu_op == 2'b11) m_data = cpu_wdata;
      check_regs();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule